// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged Receive Queue

This block recovers characters from an asynchronous serial line and queues each one with its own error flags. A free-running divider produces an oversampling tick at sixteen times the bit rate. A frame engine hunts for a start edge and confirms the start bit at its midpoint. It then samples each data bit, the optional parity bit and the stop bits at their centres. When the last stop bit has been sampled, it hands the finished character to the queue in one cycle.

The queue stores 12-bit words: the character in the low byte and four error flags above it. With the queue enabled it holds sixteen words; with it disabled it behaves as a single holding register. The block reports when nothing is waiting and raises a data request whenever a word is available. A separate timeout request signals that words have been sitting in the queue while the line has stayed idle. The line format (word length, parity and stop count) and the divisor are static inputs, changed only while the line is idle.

Top module: `uart_rx_top`

## Requirements
- R1: After reset, rxEmpty is 1, rxIrq and rxTimeoutIrq are 0 and readWord is 0x000.
- R2: The head word places the character in bits 7:0, framing error in bit 8, parity error in bit 9, overrun in bit 10 and break in bit 11. Data bits above the configured word length read as 0.
- R3: wordLen selects the data bit count: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data is received least significant bit first.
- R4: With parityEn high, a parity bit follows the data. parityEven=1 expects an even count of ones over data and parity bit, and parityEven=0 expects an odd count. A mismatch sets bit 9. With parityEn low, no parity bit is expected and bit 9 stays 0.
- R5: twoStop=1 expects two stop bits and twoStop=0 expects one. A low sample at any expected stop position sets bit 8.
- R6: One bit time lasts 16 x (divisor + 1) clock cycles.
- R7: With fifoEn=1 the queue holds 16 words; with fifoEn=0 it holds 1. Words are read in arrival order. Each readStrobe pulse removes the head word, and a readStrobe while empty has no effect.
- R8: A character that completes while the queue is full is discarded. The next word stored afterwards carries bit 10 set.
- R9: A frame whose every sample is low, including the stop position(s), is stored as 0x800 (break set, data and other error flags clear). The receiver then waits for the line to return high before it hunts for a new start.
- R10: rxEmpty is 1 exactly when no word is queued, and rxIrq is its inverse.
- R11: rxTimeoutIrq rises once the queue is non-empty and the line has been idle for 32 bit times with no read and no new character. A read or a new character clears it and restarts the count.
- R12: A start bit is confirmed at its eighth oversample. A high line there is a false start: the receiver returns to hunting and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serialIn | input | 1 | Serial line, idle high |
| wordLen | input | 2 | Data bit count select |
| parityEn | input | 1 | Parity bit present |
| parityEven | input | 1 | 1 selects even parity, 0 selects odd |
| twoStop | input | 1 | 1 selects two stop bits |
| fifoEn | input | 1 | 1 selects the 16-word queue, 0 a single holding word |
| divisor | input | DIV_W (12) | Tick divide count minus one |
| readStrobe | input | 1 | One-cycle pulse that removes the head word |
| readWord | output | 12 | Head word with error flags, 0 when empty |
| rxEmpty | output | 1 | No word is available |
| rxIrq | output | 1 | Receive data request |
| rxTimeoutIrq | output | 1 | Receive timeout request |

## Verification
A mis-sampled bit position or a wrong divide count garbles the head word of the very frame it affects. The error shows on readWord as soon as that frame's final stop sample has been taken. A queue pointer or occupancy fault appears as out-of-order words, a premature rxEmpty, or a missing overrun flag on the first word stored after a fill of sixteen. A broken idle counter shows as rxTimeoutIrq rising a couple of bit times early or late against the 32-bit-time window, or failing to drop after a read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int ENTRY_W  = 12;
  localparam int FRM_BIT  = 8;
  localparam int PAR_BIT  = 9;
  localparam int OVR_BIT  = 10;
  localparam int BRK_BIT  = 11;

  // Strobes from the frame engine to the queue
  typedef struct packed {
    logic       push;
    logic [7:0] data;
    logic       frmErr;
    logic       parErr;
    logic       brk;
    logic       busy;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_WAIT
  } rxState_t;

endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      tick   <= 1'b0;
    end else if (divCnt >= divisor) begin
      divCnt <= '0;
      tick   <= 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
      tick   <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      serialIn,
  input  logic [1:0] wordLen,
  input  logic      parityEn,
  input  logic      parityEven,
  input  logic      twoStop,
  output rxStrobe_t strobe
);
  localparam int SCW = $clog2(OVS);
  localparam logic [SCW-1:0] MID_S  = SCW'(OVS / 2 - 1);
  localparam logic [SCW-1:0] LAST_S = SCW'(OVS - 1);

  rxState_t       state;
  logic [1:0]     syncQ;
  logic           rxIn;
  logic [SCW-1:0] sampleCnt;
  logic [2:0]     bitIdx;
  logic [7:0]     shiftReg;
  logic           parAcc;
  logic           allLow;
  logic           frmFlag;

  logic           pushQ, frmQ, parQ, brkQ;
  logic [7:0]     dataQ;

  logic           sampleNow, lastStop, finishNow, frameLow, frmNow, parErrNow;
  logic [2:0]     lastIdx;
  logic [7:0]     aligned;

  assign rxIn = syncQ[1];

  always_comb begin
    sampleNow = tick && (sampleCnt == LAST_S);
    lastStop  = (state == ST_STOP2) || (state == ST_STOP1 && !twoStop);
    finishNow = sampleNow && lastStop;
    frameLow  = allLow && !rxIn;
    frmNow    = !rxIn || (state == ST_STOP2 && frmFlag);
    parErrNow = parityEn && (parityEven ? parAcc : !parAcc);
    lastIdx   = 3'd4 + {1'b0, wordLen};
    aligned   = shiftReg >> (2'd3 - wordLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], serialIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sampleCnt <= '0;
      bitIdx    <= '0;
      shiftReg  <= '0;
      parAcc    <= 1'b0;
      allLow    <= 1'b0;
      frmFlag   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (tick && !rxIn) begin
          state     <= ST_START;
          sampleCnt <= '0;
        end
        ST_START: if (tick) begin
          if (sampleCnt == MID_S) begin
            sampleCnt <= '0;
            if (rxIn) state <= ST_IDLE;
            else begin
              state    <= ST_DATA;
              bitIdx   <= '0;
              shiftReg <= '0;
              parAcc   <= 1'b0;
              allLow   <= 1'b1;
              frmFlag  <= 1'b0;
            end
          end else sampleCnt <= sampleCnt + 1'b1;
        end
        ST_WAIT: if (rxIn) state <= ST_IDLE;
        default: if (tick) begin
          if (sampleCnt != LAST_S) sampleCnt <= sampleCnt + 1'b1;
          else begin
            sampleCnt <= '0;
            allLow    <= allLow && !rxIn;
            case (state)
              ST_DATA: begin
                shiftReg <= {rxIn, shiftReg[7:1]};
                parAcc   <= parAcc ^ rxIn;
                if (bitIdx == lastIdx) state <= parityEn ? ST_PAR : ST_STOP1;
                else bitIdx <= bitIdx + 1'b1;
              end
              ST_PAR: begin
                parAcc <= parAcc ^ rxIn;
                state  <= ST_STOP1;
              end
              ST_STOP1: if (twoStop) begin
                frmFlag <= !rxIn;
                state   <= ST_STOP2;
              end else state <= rxIn ? ST_IDLE : ST_WAIT;
              default: state <= rxIn ? ST_IDLE : ST_WAIT;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushQ <= 1'b0;
      dataQ <= '0;
      frmQ  <= 1'b0;
      parQ  <= 1'b0;
      brkQ  <= 1'b0;
    end else begin
      pushQ <= finishNow;
      if (finishNow) begin
        brkQ  <= frameLow;
        dataQ <= frameLow ? 8'h00 : aligned;
        frmQ  <= frameLow ? 1'b0  : frmNow;
        parQ  <= frameLow ? 1'b0  : parErrNow;
      end
    end
  end

  always_comb begin
    strobe.push   = pushQ;
    strobe.data   = dataQ;
    strobe.frmErr = frmQ;
    strobe.parErr = parQ;
    strobe.brk    = brkQ;
    strobe.busy   = (state != ST_IDLE);
  end

  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && tick && sampleCnt == MID_S && rxIn) |=> (state == ST_IDLE && !pushQ)); // R12

  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pushQ |=> !pushQ); // R2

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  rxStrobe_t          strobe,
  input  logic               fifoEn,
  input  logic               readStrobe,
  output logic [ENTRY_W-1:0] readWord,
  output logic               rxEmpty,
  output logic               rxIrq,
  output logic               rxTimeoutIrq
);
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int TO_LIMIT = IDLE_BITS * OVS;
  localparam int TW       = $clog2(TO_LIMIT + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wrPtr, rdPtr;
  logic [CW-1:0]      count, capacity;
  logic               overrunPend;
  logic [TW-1:0]      toCnt;
  logic               popNow, roomNow, pushNow, lostNow;
  logic [ENTRY_W-1:0] entry;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    capacity = fifoEn ? CW'(DEPTH) : CW'(1);
    popNow   = readStrobe && (count != '0);
    roomNow  = (count < capacity) || popNow;
    pushNow  = strobe.push && roomNow;
    lostNow  = strobe.push && !roomNow;
    entry    = {strobe.brk, overrunPend, strobe.parErr, strobe.frmErr, strobe.data};
  end

  always_ff @(posedge clk) begin
    if (pushNow) mem[wrPtr] <= entry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      count       <= '0;
      overrunPend <= 1'b0;
    end else begin
      if (pushNow) wrPtr <= nextPtr(wrPtr);
      if (popNow)  rdPtr <= nextPtr(rdPtr);
      case ({pushNow, popNow})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (lostNow)      overrunPend <= 1'b1;
      else if (pushNow) overrunPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) toCnt <= '0;
    else if (strobe.push || popNow || strobe.busy || count == '0) toCnt <= '0;
    else if (tick && toCnt != TW'(TO_LIMIT)) toCnt <= toCnt + 1'b1;
  end

  assign readWord     = (count != '0) ? mem[rdPtr] : '0;
  assign rxEmpty      = (count == '0);
  assign rxIrq        = (count != '0);
  assign rxTimeoutIrq = (toCnt == TW'(TO_LIMIT));

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R7

  AST_LOST_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !roomNow) |=> $stable(count)); // R8

  AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxTimeoutIrq && !readStrobe && !strobe.push && !strobe.busy) |=> rxTimeoutIrq); // R11

endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top #(
  parameter int DIV_W     = 12,
  parameter int DEPTH     = 16,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serialIn,
  input  logic [1:0]       wordLen,
  input  logic             parityEn,
  input  logic             parityEven,
  input  logic             twoStop,
  input  logic             fifoEn,
  input  logic [DIV_W-1:0] divisor,
  input  logic             readStrobe,
  output logic [11:0]      readWord,
  output logic             rxEmpty,
  output logic             rxIrq,
  output logic             rxTimeoutIrq
);
  import uart_rx_pkg::*;

  logic      tick;
  rxStrobe_t strobe;

  rx_baud_gen #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rstN(rstN), .divisor(divisor), .tick(tick)
  );

  rx_ctrl #(.OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .serialIn(serialIn),
    .wordLen(wordLen), .parityEn(parityEn), .parityEven(parityEven),
    .twoStop(twoStop), .strobe(strobe)
  );

  rx_datapath #(.DEPTH(DEPTH), .OVS(OVS), .IDLE_BITS(IDLE_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe), .fifoEn(fifoEn),
    .readStrobe(readStrobe), .readWord(readWord), .rxEmpty(rxEmpty),
    .rxIrq(rxIrq), .rxTimeoutIrq(rxTimeoutIrq)
  );

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty |-> (!rxIrq && !rxTimeoutIrq && readWord == 12'h000)); // R10

  AST_BREAK_WORD: assert property (@(posedge clk) disable iff (!rstN)
    readWord[11] |-> (readWord[9:0] == 10'h000)); // R9

endmodule

// File: tb/uart_rx_top_tb_top.sv
module uart_rx_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serialIn = 1'b1;
  logic [1:0]  wordLen = 2'b11;
  logic        parityEn = 1'b0, parityEven = 1'b0, twoStop = 1'b0, fifoEn = 1'b1;
  logic [11:0] divisor = 12'd1;
  logic        readStrobe = 1'b0;
  logic [11:0] readWord;
  logic        rxEmpty, rxIrq, rxTimeoutIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_top dut_i (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .wordLen(wordLen),
    .parityEn(parityEn), .parityEven(parityEven), .twoStop(twoStop),
    .fifoEn(fifoEn), .divisor(divisor), .readStrobe(readStrobe),
    .readWord(readWord), .rxEmpty(rxEmpty), .rxIrq(rxIrq),
    .rxTimeoutIrq(rxTimeoutIrq)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bitClks();
    return 16 * (int'(divisor) + 1);
  endfunction

  function automatic logic [7:0] lenMask(input logic [1:0] wl);
    return 8'((9'd1 << (int'(wl) + 5)) - 9'd1);
  endfunction

  function automatic logic [11:0] expWord(input logic [7:0] d, input logic [1:0] wl,
      input logic pe, input logic badPar, input logic badStop, input logic ovr);
    return {1'b0, ovr, pe & badPar, badStop, d & lenMask(wl)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic badPar, input logic badStop);
    int nb = int'(wordLen) + 5;
    logic [7:0] m = d & lenMask(wordLen);
    serialIn = 1'b0; waitClk(bitClks());
    for (int i = 0; i < nb; i++) begin
      serialIn = d[i]; waitClk(bitClks());
    end
    if (parityEn) begin
      serialIn = (parityEven ? ^m : ~^m) ^ badPar; waitClk(bitClks());
    end
    serialIn = !badStop; waitClk(bitClks());
    serialIn = 1'b1;
    if (twoStop) waitClk(bitClks());
    waitClk(4);
  endtask

  task automatic readCheck(input string req, input logic [11:0] exp);
    check(req, {20'd0, readWord}, {20'd0, exp});
    readStrobe = 1'b1; waitClk(1); readStrobe = 1'b0;
  endtask

  task automatic setFmt(input logic [1:0] wl, input logic pe, input logic ev, input logic ts);
    wordLen = wl; parityEn = pe; parityEven = ev; twoStop = ts;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q [16];
    void'($urandom(32'd2024));
    waitClk(3);
    // R1 reset state
    check("R1 empty", rxEmpty, 1);
    check("R1 irq", rxIrq, 0);
    check("R1 timeout", rxTimeoutIrq, 0);
    check("R1 word", readWord, 0);
    rstN = 1'b1;
    waitClk(4);

    // R2 R3 R10 basic 8N1
    setFmt(2'b11, 0, 0, 0);
    sendFrame(8'hA5, 0, 0);
    check("R10 irq set", rxIrq, 1);
    check("R10 empty clear", rxEmpty, 0);
    readCheck("R2 8N1 word", 12'h0A5);
    check("R10 empty after read", rxEmpty, 1);

    // R3 word lengths
    for (int wl = 0; wl < 3; wl++) begin
      setFmt(2'(wl), 0, 0, 0);
      sendFrame(8'hFF, 0, 0);
      readCheck("R3 short word", expWord(8'hFF, 2'(wl), 0, 0, 0, 0));
      sendFrame(8'h96, 0, 0);
      readCheck("R3 lsb first", expWord(8'h96, 2'(wl), 0, 0, 0, 0));
    end

    // R4 parity
    setFmt(2'b11, 1, 1, 0);
    sendFrame(8'h37, 0, 0); readCheck("R4 even good", 12'h037);
    sendFrame(8'h37, 1, 0); readCheck("R4 even bad", 12'h237);
    setFmt(2'b10, 1, 0, 0);
    sendFrame(8'h51, 1, 0); readCheck("R4 odd bad", expWord(8'h51, 2'b10, 1, 1, 0, 0));
    sendFrame(8'h51, 0, 0); readCheck("R4 odd good", expWord(8'h51, 2'b10, 1, 0, 0, 0));

    // R5 stop bits and framing
    setFmt(2'b11, 0, 0, 0);
    sendFrame(8'h3C, 0, 1); readCheck("R5 framing", 12'h13C);
    setFmt(2'b11, 0, 0, 1);
    sendFrame(8'hC3, 0, 0); readCheck("R5 two stop good", 12'h0C3);
    sendFrame(8'hC3, 0, 1); readCheck("R5 two stop first low", 12'h1C3);

    // R6 divisor
    setFmt(2'b11, 0, 0, 0);
    divisor = 12'd3; waitClk(20);
    sendFrame(8'h5A, 0, 0); readCheck("R6 div 3", 12'h05A);
    divisor = 12'd0; waitClk(20);
    sendFrame(8'h81, 0, 0); readCheck("R6 div 0", 12'h081);
    divisor = 12'd1; waitClk(20);

    // R7 order and read while empty
    readStrobe = 1'b1; waitClk(1); readStrobe = 1'b0;
    check("R7 empty read ignored", rxEmpty, 1);
    sendFrame(8'h11, 0, 0); sendFrame(8'h22, 0, 0); sendFrame(8'h33, 0, 0);
    readCheck("R7 order 1", 12'h011);
    readCheck("R7 order 2", 12'h022);
    readCheck("R7 order 3", 12'h033);
    check("R7 drained", rxEmpty, 1);

    // R8 single holding word
    fifoEn = 1'b0;
    sendFrame(8'hAA, 0, 0); sendFrame(8'hBB, 0, 0);
    readCheck("R8 held word kept", 12'h0AA);
    check("R8 lost word absent", rxEmpty, 1);
    sendFrame(8'hCC, 0, 0);
    readCheck("R8 overrun tag", 12'h4CC);
    fifoEn = 1'b1;

    // R7 R8 full queue
    for (int i = 0; i < 16; i++) begin
      q[i] = 8'($urandom);
      sendFrame(q[i], 0, 0);
    end
    sendFrame(8'hEE, 0, 0);
    for (int i = 0; i < 16; i++) readCheck("R7 deep queue", {4'h0, q[i]});
    check("R8 extra discarded", rxEmpty, 1);
    sendFrame(8'h42, 0, 0);
    readCheck("R8 overrun after full", 12'h442);
    sendFrame(8'h43, 0, 0);
    readCheck("R8 flag cleared", 12'h043);

    // R9 break
    serialIn = 1'b0; waitClk(12 * bitClks());
    serialIn = 1'b1; waitClk(2 * bitClks());
    readCheck("R9 break word", 12'h800);
    check("R9 single entry", rxEmpty, 1);

    // R12 false start
    serialIn = 1'b0; waitClk(6);
    serialIn = 1'b1; waitClk(3 * bitClks());
    check("R12 false start", rxEmpty, 1);
    sendFrame(8'h6E, 0, 0);
    readCheck("R12 recovers", 12'h06E);

    // R11 timeout
    sendFrame(8'h01, 0, 0);
    waitClk(30 * bitClks());
    check("R11 not yet", rxTimeoutIrq, 0);
    waitClk(3 * bitClks());
    check("R11 fires", rxTimeoutIrq, 1);
    readCheck("R11 word", 12'h001);
    check("R11 cleared by read", rxTimeoutIrq, 0);
    sendFrame(8'h02, 0, 0);
    waitClk(33 * bitClks());
    check("R11 fires again", rxTimeoutIrq, 1);
    sendFrame(8'h03, 0, 0);
    check("R11 cleared by char", rxTimeoutIrq, 0);
    readCheck("R11 first", 12'h002);
    readCheck("R11 second", 12'h003);

    // random formats
    for (int n = 0; n < 30; n++) begin
      logic [7:0] d = 8'($urandom);
      logic bp = ($urandom % 6) == 0;
      logic bs = ($urandom % 8) == 0;
      setFmt(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      divisor = 12'($urandom % 3);
      if (bs && (d & lenMask(wordLen)) == 0) d = 8'h01;
      waitClk(8);
      sendFrame(d, bp, bs);
      readCheck("R3 R4 R5 random", expWord(d, wordLen, parityEn, bp, bs, 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule